// File: doc/BRIEF.md
# Next Fetch Address Unit with One-Slot Delayed Redirect

This block owns the program counter of a simple in-order core and chooses the next fetch address on every clock edge. The decode stage describes the instruction that sits at the current address. It sends a conditional-equal branch flag, an unconditional jump flag, a 16-bit word offset, a 26-bit jump index, and the zero result of the register comparison that the branch needs. The block returns the current address and that address plus four.

Control transfers take effect one instruction late. When a branch is taken or a jump is seen, the block still fetches the instruction that follows it, the slot instruction. It holds the computed target in a pending register and loads it into the counter on the next edge. A transfer that shows up in the slot is ignored, so the first pending target always wins. The targets are relative to the slot address: the branch target is the slot address plus the scaled offset, and the jump keeps the top four bits of the slot address.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, the counter is held at 0x00000000 and any pending redirect is dropped, whatever the clock is doing. After release, the first edge moves the counter to 0x00000004.
- R2: With no redirect pending and no transfer taken, the counter advances by 4 on each edge. `pc_plus4_o` always equals `pc_o + 4`.
- R3: A branch is taken when `br_eq_i` and `cmp_zero_i` are both 1. Its target is `pc_o + 4 + (sign-extended br_off_i << 2)`, and negative offsets move backwards.
- R4: When `br_eq_i` is 1 and `cmp_zero_i` is 0, flow continues at `pc_o + 4`. When `cmp_zero_i` is 1 and `br_eq_i` is 0, the comparison result has no effect.
- R5: A jump (`jump_i` = 1) targets `{slot[31:28], jmp_idx_i, 2'b00}`, where slot = `pc_o + 4`.
- R6: On the edge after a taken transfer the counter moves to the slot address (transfer address + 4). On the edge after that it loads the target.
- R7: A branch or jump presented while the counter points at a slot instruction is ignored. The earlier target is applied unchanged.
- R8: When `jump_i` and a taken branch occur together, the jump target is used.
- R9: The two low bits of `pc_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_eq_i | input | 1 | Current instruction is a branch-if-equal |
| jump_i | input | 1 | Current instruction is an unconditional jump |
| br_off_i | input | 16 | Signed branch offset in words |
| jmp_idx_i | input | 26 | Jump index in words |
| cmp_zero_i | input | 1 | Register comparison result is zero (operands equal) |
| pc_o | output | 32 | Current fetch address |
| pc_plus4_o | output | 32 | Current fetch address plus 4 |

## Verification
The bench follows a program path through taken and not-taken branches, a backward branch, and a jump. A design that redirects at once, without the slot, skips the slot address and fails the check that expects it. A design that bases targets on the transfer address instead of the slot address lands 4 bytes short. A transfer placed in the slot checks the first-target-wins rule: a design that lets it through goes to the wrong place. A combined jump and taken branch checks which one has priority. Dropping reset while a target is pending checks that the stale redirect is discarded.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned STEP_B  = 4;
  localparam logic [ADDR_W-1:0] RESET_PC = '0;
endpackage

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  input  logic [IW-1:0] idx_i,
  input  logic          jump_sel_i,
  output logic [AW-1:0] slot_o,
  output logic [AW-1:0] tgt_o
);
  localparam int unsigned EXT_W = AW - OW - 2;
  localparam int unsigned HI_W  = AW - IW - 2;

  logic [AW-1:0] off_scaled;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] jmp_tgt;

  assign slot_o     = pc_i + AW'(STEP_B);
  assign off_scaled = {{EXT_W{off_i[OW-1]}}, off_i, 2'b00};
  assign br_tgt     = slot_o + off_scaled;
  // upper bits follow the slot address, same base as branches
  assign jmp_tgt    = {slot_o[AW-1 -: HI_W], idx_i, 2'b00};
  assign tgt_o      = jump_sel_i ? jmp_tgt : br_tgt;
endmodule

// File: rtl/npc_redirect.sv
module npc_redirect
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] tgt_i,
  output logic          pend_vld_o,
  output logic [AW-1:0] pend_tgt_o
);
  logic arm;

  // a transfer sitting in the slot is dropped
  assign arm = take_i && !pend_vld_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o <= 1'b0;
      pend_tgt_o <= '0;
    end else begin
      pend_vld_o <= arm;
      if (arm) pend_tgt_o <= tgt_i;
    end
  end

  // R6
  redirect_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !pend_vld_o) |=> pend_vld_o);

  // R7
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |=> (!pend_vld_o && $stable(pend_tgt_o)));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_eq_i,
  input  logic          jump_i,
  input  logic [OW-1:0] br_off_i,
  input  logic [IW-1:0] jmp_idx_i,
  input  logic          cmp_zero_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] pc_plus4_o
);
  logic          take;
  logic [AW-1:0] tgt;
  logic          pend_vld;
  logic [AW-1:0] pend_tgt;
  logic [AW-1:0] pc_next;

  assign take = jump_i || (br_eq_i && cmp_zero_i);

  npc_target #(.AW(AW), .OW(OW), .IW(IW)) u_tgt (
    .pc_i       (pc_o),
    .off_i      (br_off_i),
    .idx_i      (jmp_idx_i),
    .jump_sel_i (jump_i),
    .slot_o     (pc_plus4_o),
    .tgt_o      (tgt)
  );

  npc_redirect #(.AW(AW)) u_rdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .tgt_i      (tgt),
    .pend_vld_o (pend_vld),
    .pend_tgt_o (pend_tgt)
  );

  assign pc_next = pend_vld ? pend_tgt : pc_plus4_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= RESET_PC;
    else         pc_o <= pc_next;
  end

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_vld |=> (pc_o == $past(pc_o) + AW'(STEP_B)));

  // R9
  always_comb begin
    if (rst_ni) align_chk: assert (pc_o[1:0] == 2'b00);
  end
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_eq = 1'b0;
  logic        jump = 1'b0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic        cmp_zero = 1'b0;
  logic [31:0] pc;
  logic [31:0] pc4;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  npc_unit u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .br_eq_i    (br_eq),
    .jump_i     (jump),
    .br_off_i   (br_off),
    .jmp_idx_i  (jmp_idx),
    .cmp_zero_i (cmp_zero),
    .pc_o       (pc),
    .pc_plus4_o (pc4)
  );

  // {req, br, jmp, zero, off, idx, expected pc before the edge}
  localparam int NV = 14;
  localparam logic [80:0] VEC [NV] = '{
    {4'd2, 3'b000, 16'h0000, 26'h0,     32'h0000_0000},
    {4'd3, 3'b101, 16'h0010, 26'h0,     32'h0000_0004}, // R3 taken, target 0x48
    {4'd6, 3'b010, 16'h0000, 26'h3ff,   32'h0000_0008}, // R6 slot, R7 jump ignored
    {4'd3, 3'b100, 16'h0005, 26'h0,     32'h0000_0048}, // R3 landed; R4 not taken
    {4'd4, 3'b000, 16'h0000, 26'h0,     32'h0000_004c},
    {4'd4, 3'b101, 16'hfffc, 26'h0,     32'h0000_0050}, // R3 backward, target 0x44
    {4'd6, 3'b000, 16'h0000, 26'h0,     32'h0000_0054},
    {4'd3, 3'b010, 16'h0000, 26'h100,   32'h0000_0044}, // R5 jump to 0x400
    {4'd6, 3'b000, 16'h0000, 26'h0,     32'h0000_0048},
    {4'd5, 3'b000, 16'h0000, 26'h0,     32'h0000_0400},
    {4'd2, 3'b111, 16'h0001, 26'h3,     32'h0000_0404}, // R8 jump wins -> 0xC
    {4'd6, 3'b000, 16'h0000, 26'h0,     32'h0000_0408},
    {4'd8, 3'b001, 16'h0000, 26'h0,     32'h0000_000c}, // R4 zero alone ignored
    {4'd4, 3'b000, 16'h0000, 26'h0,     32'h0000_0010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset pc", pc, 32'h0);
    @(negedge clk);
    check("R1 held in reset", pc, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {br_eq, jump, cmp_zero} = VEC[i][76:74];
      br_off  = VEC[i][73:58];
      jmp_idx = VEC[i][57:32];
      #0;
      check($sformatf("R%0d vec %0d pc", VEC[i][80:77], i), pc, VEC[i][31:0]);
      check($sformatf("R2 vec %0d plus4", i), pc4, VEC[i][31:0] + 32'd4);
      @(negedge clk);
    end
    check("R2 after table", pc, 32'h14);

    // R1: reset with a redirect pending drops it
    br_eq = 1'b1; cmp_zero = 1'b1; br_off = 16'h0100; jump = 1'b0;
    @(negedge clk);
    br_eq = 1'b0; cmp_zero = 1'b0;
    check("R6 slot before reset", pc, 32'h18);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pending cleared", pc, 32'h4);

    // R7: branch in slot of a branch ignored
    br_eq = 1'b1; cmp_zero = 1'b1; br_off = 16'h0008; // target 0x8+0x20=0x28
    @(negedge clk);
    br_off = 16'h0040;
    check("R7 slot", pc, 32'h8);
    @(negedge clk);
    br_eq = 1'b0; cmp_zero = 1'b0;
    check("R7 first target wins", pc, 32'h28);
    @(negedge clk);
    check("R2 after redirect", pc, 32'h2c);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule